// File: doc/BRIEF.md
# Periodic SPI Burst Sequencer

This block runs repeated SPI bursts with no processor work per word. It holds 128 transmit word slots and 128 receive word slots. Four 32-bit selection masks pick which slots take part in a burst, and slot number `k*32 + b` belongs to bit `b` of mask `k`. A burst can start in two ways: an internal period counter expires, or an external trigger pulse arrives. During a burst the sequencer sends each selected transmit word, one at a time, to a single-word serial engine over a valid/ready stream. It stores each returned word in the receive slot with the same number.

Software uses a simple word-addressed register port. Through it, software fills the slots, programs the masks, the period, the start source and the two slave-select patterns, and reads results and event flags back. The block also offers a one-word manual transfer path. That path works only while automated mode is off.

Both streams follow the usual rule: a word moves on a clock edge where valid and ready are both high. On `xfer_*` the sequencer holds `xfer_valid` and `xfer_data` steady until `xfer_ready` is seen. The engine may stall for as long as it needs. On `res_*` the engine must hold `res_valid` and `res_data` until `res_ready`. `res_ready` is high only while a word is outstanding, so at most one word is ever in flight.

Top module: `spi_auto_burst`

Register map (word addresses, with NSLOT = 128):
- `0..127`: transmit slots (read/write).
- `128..255`: receive slots (read only).
- `256..259`: masks 0 to 3.
- `264`: period.
- `265`: start control.
- `266`: mode.
- `267`: events.
- `268`: idle slave-select pattern.
- `269`: burst slave-select pattern.
- `270`: manual transmit word (write).
- `271`: manual result (read).

## Requirements
- R1: After reset the block is in this state:
  - `ss_o` is all ones and `busy_o` and `xfer_valid` are low.
  - The event register reads 0.
  - Every receive slot reads 0.
- R2: In a burst, only the slots whose mask bit is set are transferred. Slot `k*32+b` belongs to bit `b` of mask `k`. Each returned word lands in the receive slot with the same number, and receive slots that are not selected keep their value.
- R3: Within one burst, the selected slots are sent in ascending slot order.
- R4: Writing the start-control register with bit 1 set (periodic), when it was clear before, loads the period counter with P. This arms timer bursts. While the counter runs, a burst starts every P+1 clock cycles, because the counter reloads P at each burst start.
- R5: With start-control bit 0 set (external arm), mode bits 0 and 1 set, and no burst running, a one-cycle `ext_trig` pulse starts exactly one burst. `busy_o` rises on the edge that samples the pulse. Arming alone starts nothing.
- R6: Writing 0 to the start-control register stops further bursts.
- R7: An `ext_trig` pulse during a running burst starts no burst. Instead it sets the sticky overrun flag, bit 1 of the event register. Writing a 1 to that bit clears the flag.
- R8: With mode bit 2 set, `ss_o` carries the burst pattern while a burst runs. At all other times `ss_o` carries the idle pattern.
- R9: Bit 0 of the event register (results ready) is set one edge after the last result of a burst is accepted. For an empty mask it is set at the end of the burst. Writing a 1 to that bit clears it.
- R10: A write to the manual transmit word launches one transfer only when mode bit 0 (enable) is set and mode bit 1 (automated) is clear. The result then appears in the manual result register. With mode bit 1 set, the write is ignored.
- R11: A write to a transmit slot is kept only while mode bit 0 (enable) is set.
- R12: `xfer_valid` and `xfer_data` hold steady until accepted. After an accept, `xfer_valid` stays low until the result has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe; data is valid on `reg_rdata` one cycle later |
| reg_addr | input | 9 | word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data |
| ext_trig | input | 1 | external burst trigger pulse |
| xfer_valid | output | 1 | word offered to the serial engine |
| xfer_ready | input | 1 | engine accepts the word |
| xfer_data | output | 32 | transmit word |
| res_valid | input | 1 | engine returns a word |
| res_ready | output | 1 | sequencer accepts the returned word |
| res_data | input | 32 | received word |
| ss_o | output | 8 | slave-select pattern |
| busy_o | output | 1 | a burst is running |
| done_o | output | 1 | one-cycle pulse at the end of a burst |

## Verification
Each result has a fixed cycle in which it is due:
- Register read data appears one edge after the read strobe.
- `busy_o` is high one edge after the trigger is sampled.
- A periodic burst start falls exactly P+1 edges after the previous one.
- The results-ready flag follows the last result handshake by one edge.

The bench drives all inputs at falling edges and samples at the next falling edge, so every check lands half a cycle after the edge that produced its result. A scoreboard queues the expected transmit words and slave-select values in ascending slot order. At every accepted handshake it pops one entry and compares, so a missing, extra or reordered transfer is caught in the cycle where it happens. Burst start times are logged from `busy_o` rising and compared as differences against P+1.

// File: rtl/asb_pkg.sv
package asb_pkg;
  localparam int WORD_W = 32;
  localparam int MASK_W = 32;

  // register offsets above the slot windows
  localparam int OFS_MASK     = 0;
  localparam int OFS_PERIOD   = 8;
  localparam int OFS_START    = 9;
  localparam int OFS_MODE     = 10;
  localparam int OFS_EVENT    = 11;
  localparam int OFS_SS_IDLE  = 12;
  localparam int OFS_SS_BURST = 13;
  localparam int OFS_MAN_TX   = 14;
  localparam int OFS_MAN_RX   = 15;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PICK, SQ_ISSUE, SQ_WAIT} sq_state_t;

  typedef struct packed {
    logic ss_auto;
    logic auto_en;
    logic core_en;
  } mode_t;

  typedef struct packed {
    logic periodic;
    logic ext_arm;
  } start_t;
endpackage

// File: rtl/asb_regs.sv
module asb_regs import asb_pkg::*; #(
  parameter int NSLOT = 128,
  parameter int SS_W  = 8,
  parameter int PER_W = 32,
  localparam int SW       = $clog2(NSLOT),
  localparam int REG_BASE = 2 * NSLOT,
  localparam int ADRW     = $clog2(REG_BASE + 16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADRW-1:0]   addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [NSLOT-1:0]  mask_flat,
  output logic [PER_W-1:0]  period,
  output start_t            start_cfg,
  output mode_t             mode,
  output logic [SS_W-1:0]   ss_idle,
  output logic [SS_W-1:0]   ss_burst,
  output logic              arm_per,
  output logic              man_go,
  output logic [WORD_W-1:0] man_word,
  input  logic [SW-1:0]     tx_idx,
  output logic [WORD_W-1:0] tx_word,
  input  logic              rx_we,
  input  logic [SW-1:0]     rx_idx,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              ne_set,
  input  logic              ovr_set,
  input  logic              man_rx_we,
  input  logic [WORD_W-1:0] man_rx_word,
  output logic              ev_ne,
  output logic              ev_ovr
);
  localparam int NMASK = NSLOT / MASK_W;

  logic [WORD_W-1:0] tx_mem [NSLOT];
  logic [WORD_W-1:0] rx_mem [NSLOT];
  logic [MASK_W-1:0] mask_q [NMASK];
  logic [WORD_W-1:0] man_rx_q;
  logic [WORD_W-1:0] rd_next;

  logic       is_tx, is_rx, is_reg;
  logic [3:0] ofs;
  logic       reg_wr;

  assign is_tx  = addr < ADRW'(NSLOT);
  assign is_rx  = !is_tx && (addr < ADRW'(REG_BASE));
  assign is_reg = (addr >= ADRW'(REG_BASE)) && (addr < ADRW'(REG_BASE + 16));
  assign ofs    = 4'(addr - ADRW'(REG_BASE));
  assign reg_wr = wr && is_reg;

  generate
    for (genvar g = 0; g < NMASK; g++) begin : g_flat
      assign mask_flat[g*MASK_W +: MASK_W] = mask_q[g];
    end
  endgenerate

  assign tx_word  = tx_mem[tx_idx];
  assign arm_per  = reg_wr && (ofs == 4'(OFS_START)) && wdata[1] && !start_cfg.periodic;
  assign man_go   = reg_wr && (ofs == 4'(OFS_MAN_TX)) && mode.core_en && !mode.auto_en;
  assign man_word = wdata;

  // transmit slots: software side only, gated by core enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) tx_mem[i] <= '0;
    end else if (wr && is_tx && mode.core_en) begin
      tx_mem[addr[SW-1:0]] <= wdata;
    end
  end

  // receive slots: sequencer side only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) rx_mem[i] <= '0;
    end else if (rx_we) begin
      rx_mem[rx_idx] <= rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NMASK; m++) mask_q[m] <= '0;
      period    <= '0;
      start_cfg <= '0;
      mode      <= '0;
      ss_idle   <= '1;
      ss_burst  <= '1;
      man_rx_q  <= '0;
      ev_ne     <= 1'b0;
      ev_ovr    <= 1'b0;
    end else begin
      for (int m = 0; m < NMASK; m++)
        if (reg_wr && (ofs == 4'(OFS_MASK + m))) mask_q[m] <= wdata[MASK_W-1:0];
      if (reg_wr && (ofs == 4'(OFS_PERIOD)))   period    <= wdata[PER_W-1:0];
      if (reg_wr && (ofs == 4'(OFS_START)))    start_cfg <= start_t'(wdata[1:0]);
      if (reg_wr && (ofs == 4'(OFS_MODE)))     mode      <= mode_t'(wdata[2:0]);
      if (reg_wr && (ofs == 4'(OFS_SS_IDLE)))  ss_idle   <= wdata[SS_W-1:0];
      if (reg_wr && (ofs == 4'(OFS_SS_BURST))) ss_burst  <= wdata[SS_W-1:0];
      if (man_rx_we) man_rx_q <= man_rx_word;
      // set wins over a same-cycle clear
      ev_ne  <= ne_set  | (ev_ne  & !(reg_wr && (ofs == 4'(OFS_EVENT)) && wdata[0]));
      ev_ovr <= ovr_set | (ev_ovr & !(reg_wr && (ofs == 4'(OFS_EVENT)) && wdata[1]));
    end
  end

  always_comb begin
    rd_next = '0;
    if (is_tx) begin
      rd_next = tx_mem[addr[SW-1:0]];
    end else if (is_rx) begin
      rd_next = rx_mem[addr[SW-1:0]];
    end else if (is_reg) begin
      for (int m = 0; m < NMASK; m++)
        if (ofs == 4'(OFS_MASK + m)) rd_next = WORD_W'(mask_q[m]);
      case (ofs)
        4'(OFS_PERIOD):   rd_next = WORD_W'(period);
        4'(OFS_START):    rd_next = WORD_W'(start_cfg);
        4'(OFS_MODE):     rd_next = WORD_W'(mode);
        4'(OFS_EVENT):    rd_next = WORD_W'({ev_ovr, ev_ne});
        4'(OFS_SS_IDLE):  rd_next = WORD_W'(ss_idle);
        4'(OFS_SS_BURST): rd_next = WORD_W'(ss_burst);
        4'(OFS_MAN_RX):   rd_next = man_rx_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/asb_trig.sv
module asb_trig import asb_pkg::*; #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  start_t           start_cfg,
  input  logic             enabled,
  input  logic [PER_W-1:0] period,
  input  logic             arm_per,
  input  logic             ext_trig,
  input  logic             busy,
  output logic             start,
  output logic             ovr_set
);
  logic [PER_W-1:0] cnt;
  logic per_run, per_due, ext_hit;

  assign per_run = start_cfg.periodic && enabled;
  assign per_due = per_run && (cnt == '0);
  assign ext_hit = start_cfg.ext_arm && enabled && ext_trig;
  assign start   = !busy && (per_due || ext_hit);
  assign ovr_set = busy && ext_hit;

  // reload on arm and at every burst start; a due count waits at zero
  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (arm_per || start)        cnt <= period;
    else if (per_run && cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/asb_pick.sv
module asb_pick #(
  parameter int N = 128,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign any = |pend;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) idx = IW'(i);
  end
endmodule

// File: rtl/asb_seq.sv
module asb_seq import asb_pkg::*; #(
  parameter int NSLOT = 128,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NSLOT-1:0]  mask_flat,
  input  logic              man_go,
  input  logic [WORD_W-1:0] man_word,
  output logic [SW-1:0]     tx_idx,
  input  logic [WORD_W-1:0] tx_word,
  output logic              rx_we,
  output logic [SW-1:0]     rx_idx,
  output logic [WORD_W-1:0] rx_word,
  output logic              ne_set,
  output logic              man_rx_we,
  output logic [WORD_W-1:0] man_rx_word,
  output logic              busy,
  output logic              in_burst,
  output logic              done,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [WORD_W-1:0] xfer_data,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data
);
  sq_state_t         st;
  logic [NSLOT-1:0]  pend;
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] man_q;
  logic              any;
  logic [SW-1:0]     next_slot;

  asb_pick #(.N(NSLOT)) u_pick (.pend(pend), .any(any), .idx(next_slot));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      pend     <= '0;
      slot     <= '0;
      man_q    <= '0;
      in_burst <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            pend     <= mask_flat;
            in_burst <= 1'b1;
            st       <= SQ_PICK;
          end else if (man_go) begin
            man_q <= man_word;
            st    <= SQ_ISSUE;
          end
        end
        SQ_PICK: begin
          if (any) begin
            slot <= next_slot;
            st   <= SQ_ISSUE;
          end else begin
            in_burst <= 1'b0;
            st       <= SQ_IDLE;
          end
        end
        SQ_ISSUE: if (xfer_ready) st <= SQ_WAIT;
        SQ_WAIT: begin
          if (res_valid) begin
            if (in_burst) begin
              pend[slot] <= 1'b0;
              st         <= SQ_PICK;
            end else begin
              st <= SQ_IDLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = st != SQ_IDLE;
  assign done        = (st == SQ_PICK) && !any;
  assign ne_set      = done;
  assign xfer_valid  = st == SQ_ISSUE;
  assign xfer_data   = in_burst ? tx_word : man_q;
  assign res_ready   = st == SQ_WAIT;
  assign tx_idx      = slot;
  assign rx_idx      = slot;
  assign rx_word     = res_data;
  assign rx_we       = res_ready && res_valid && in_burst;
  assign man_rx_we   = res_ready && res_valid && !in_burst;
  assign man_rx_word = res_data;
endmodule

// File: rtl/spi_auto_burst.sv
module spi_auto_burst import asb_pkg::*; #(
  parameter int NSLOT = 128,
  parameter int SS_W  = 8,
  parameter int PER_W = 32,
  localparam int SW   = $clog2(NSLOT),
  localparam int ADRW = $clog2(2 * NSLOT + 16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADRW-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [WORD_W-1:0] xfer_data,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data,
  output logic [SS_W-1:0]   ss_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [NSLOT-1:0]  mask_flat;
  logic [PER_W-1:0]  period;
  start_t            start_cfg;
  mode_t             mode;
  logic [SS_W-1:0]   ss_idle, ss_burst;
  logic              arm_per, man_go;
  logic [WORD_W-1:0] man_word;
  logic [SW-1:0]     tx_idx, rx_idx;
  logic [WORD_W-1:0] tx_word, rx_word, man_rx_word;
  logic              rx_we, ne_set, ovr_set, man_rx_we;
  logic              ev_ne, ev_ovr;
  logic              start, seq_busy, in_burst;

  asb_regs #(.NSLOT(NSLOT), .SS_W(SS_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mask_flat(mask_flat), .period(period),
    .start_cfg(start_cfg), .mode(mode), .ss_idle(ss_idle), .ss_burst(ss_burst),
    .arm_per(arm_per), .man_go(man_go), .man_word(man_word),
    .tx_idx(tx_idx), .tx_word(tx_word), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_word(rx_word), .ne_set(ne_set), .ovr_set(ovr_set),
    .man_rx_we(man_rx_we), .man_rx_word(man_rx_word),
    .ev_ne(ev_ne), .ev_ovr(ev_ovr)
  );

  asb_trig #(.PER_W(PER_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .start_cfg(start_cfg),
    .enabled(mode.core_en && mode.auto_en), .period(period), .arm_per(arm_per),
    .ext_trig(ext_trig), .busy(seq_busy), .start(start), .ovr_set(ovr_set)
  );

  asb_seq #(.NSLOT(NSLOT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_flat(mask_flat),
    .man_go(man_go), .man_word(man_word), .tx_idx(tx_idx), .tx_word(tx_word),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_word(rx_word), .ne_set(ne_set),
    .man_rx_we(man_rx_we), .man_rx_word(man_rx_word), .busy(seq_busy),
    .in_burst(in_burst), .done(done_o), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_data(xfer_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  assign busy_o = in_burst;
  assign ss_o   = (in_burst && mode.ss_auto) ? ss_burst : ss_idle;
endmodule

// File: rtl/asb_chk.sv
module asb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_valid,
  input logic        xfer_ready,
  input logic [31:0] xfer_data,
  input logic        res_ready,
  input logic        busy_o,
  input logic        done_o,
  input logic        reg_wr,
  input logic        ev_ovr
);
  // R12
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_data));

  // R12
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> !xfer_valid);

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && res_ready));

  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr && !reg_wr |=> ev_ovr);
endmodule

bind spi_auto_burst asb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_data(xfer_data), .res_ready(res_ready), .busy_o(busy_o),
  .done_o(done_o), .reg_wr(reg_wr), .ev_ovr(ev_ovr)
);

// File: tb/spi_auto_burst_tb.sv
module spi_auto_burst_tb_top;
  localparam int BASE   = 256;
  localparam int A_RX   = 128;
  localparam int A_MSK  = BASE + 0;
  localparam int A_PER  = BASE + 8;
  localparam int A_STA  = BASE + 9;
  localparam int A_MODE = BASE + 10;
  localparam int A_EVT  = BASE + 11;
  localparam int A_SSI  = BASE + 12;
  localparam int A_SSB  = BASE + 13;
  localparam int A_MTX  = BASE + 14;
  localparam int A_MRX  = BASE + 15;
  localparam int LAT    = 3;
  localparam int PER    = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, ext_trig;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_valid, xfer_ready, res_valid, res_ready;
  logic [31:0] xfer_data, res_data;
  logic [7:0]  ss_o;
  logic        busy_o, done_o;

  always #10 clk = ~clk;

  spi_auto_burst dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_trig(ext_trig), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_data(xfer_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .ss_o(ss_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_xfer = 0, n_burst = 0;
  int start_cyc[16];
  bit bp = 1'b0;
  string sb_req = "R2/R3";
  logic [31:0] exp_data_q[$];
  logic [7:0]  exp_ss_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] tv(input int s);
    return 32'hC0DE_0000 | 32'(s);
  endfunction

  // serial engine model plus scoreboard monitor
  initial begin
    int lat_cnt = 0;
    bit res_acc = 1'b0, prev_busy = 1'b0;
    logic [31:0] held = '0;
    res_valid = 1'b0;
    res_data  = '0;
    xfer_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (busy_o && !prev_busy) begin
        if (n_burst < 16) start_cyc[n_burst] = cyc;
        n_burst++;
      end
      prev_busy = busy_o;
      if (res_acc) begin res_valid = 1'b0; res_acc = 1'b0; end
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin res_valid = 1'b1; res_data = ~held; end
      end
      if (res_valid && res_ready) res_acc = 1'b1;
      xfer_ready = bp ? ~xfer_ready : 1'b1;
      if (xfer_valid && xfer_ready) begin
        n_xfer++;
        held = xfer_data;
        lat_cnt = LAT;
        if (exp_data_q.size() == 0) begin
          check(1'b0, {sb_req, " unexpected transfer"}, xfer_data, 32'h0);
        end else begin
          logic [31:0] ed;
          logic [7:0]  es;
          ed = exp_data_q.pop_front();
          es = exp_ss_q.pop_front();
          check(xfer_data == ed, {sb_req, " word"}, xfer_data, ed);
          check(ss_o == es, "R8 ss during burst", 32'(ss_o), 32'(es));
        end
      end
    end
  end

  task automatic push(input logic [31:0] d, input logic [7:0] s);
    exp_data_q.push_back(d);
    exp_ss_q.push_back(s);
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 9'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 9'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int b0, x0;
    int sl[5] = '{0, 5, 32, 70, 127};
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; ext_trig = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(ss_o == 8'hFF, "R1 ss idle", 32'(ss_o), 32'hFF);
    check(!busy_o && !xfer_valid, "R1 idle", 32'({busy_o, xfer_valid}), 32'h0);
    reg_read(A_EVT, r);
    check(r == 0, "R1 events", r, 0);
    reg_read(A_RX + 9, r);
    check(r == 0, "R1 rx slot", r, 0);

    // R11 tx writes dropped while disabled
    reg_write(5, 32'h1234);
    reg_read(5, r);
    check(r == 0, "R11 dropped", r, 0);
    reg_write(A_MODE, 1);
    reg_write(5, 32'h1111_0005);
    reg_read(5, r);
    check(r == 32'h1111_0005, "R11 kept", r, 32'h1111_0005);

    // burst via external trigger
    foreach (sl[i]) reg_write(sl[i], tv(sl[i]));
    reg_write(31, tv(31));
    reg_write(A_MSK + 0, 32'h0000_0021);
    reg_write(A_MSK + 1, 32'h0000_0001);
    reg_write(A_MSK + 2, 32'h0000_0040);
    reg_write(A_MSK + 3, 32'h8000_0000);
    reg_write(A_SSI, 32'hFF);
    reg_write(A_SSB, 32'hF7);
    reg_write(A_MODE, 7);
    reg_write(A_STA, 1);
    repeat (5) @(negedge clk);
    check(!busy_o, "R5 arm alone", 32'(busy_o), 0);
    sb_req = "R2/R3";
    foreach (sl[i]) push(tv(sl[i]), 8'hF7);
    b0 = n_burst;
    pulse_trig();
    check(busy_o, "R5 busy after trigger", 32'(busy_o), 1);
    check(ss_o == 8'hF7, "R8 burst pattern", 32'(ss_o), 32'hF7);
    pulse_trig();
    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_data_q.size() == 0, "R2 all slots sent", 32'(exp_data_q.size()), 0);
    check(n_burst == b0 + 1, "R7 trigger in burst ignored", 32'(n_burst - b0), 1);
    check(ss_o == 8'hFF, "R8 idle after burst", 32'(ss_o), 32'hFF);
    foreach (sl[i]) begin
      reg_read(A_RX + sl[i], r);
      check(r == ~tv(sl[i]), "R2 rx slot", r, ~tv(sl[i]));
    end
    reg_read(A_RX + 31, r);
    check(r == 0, "R2 unselected rx", r, 0);
    reg_read(A_EVT, r);
    check(r == 3, "R9/R7 events", r, 3);
    reg_write(A_EVT, 1);
    reg_read(A_EVT, r);
    check(r == 2, "R9 clear", r, 2);
    reg_write(A_EVT, 2);
    reg_read(A_EVT, r);
    check(r == 0, "R7 clear", r, 0);

    // back-pressure, auto slave select off
    bp = 1'b1;
    reg_write(A_MODE, 3);
    sb_req = "R12";
    foreach (sl[i]) push(tv(sl[i]), 8'hFF);
    pulse_trig();
    check(ss_o == 8'hFF, "R8 no auto select", 32'(ss_o), 32'hFF);
    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_data_q.size() == 0, "R12 all sent", 32'(exp_data_q.size()), 0);
    bp = 1'b0;
    reg_write(A_EVT, 3);

    // empty mask
    for (int m = 0; m < 4; m++) reg_write(A_MSK + m, 0);
    x0 = n_xfer;
    sb_req = "R9";
    pulse_trig();
    repeat (5) @(negedge clk);
    reg_read(A_EVT, r);
    check(r == 1, "R9 empty mask done", r, 1);
    check(n_xfer == x0, "R9 empty no transfer", 32'(n_xfer - x0), 0);

    // periodic bursts
    reg_write(A_MODE, 7);
    reg_write(A_MSK + 2, 32'h40);
    reg_write(A_PER, PER);
    sb_req = "R4";
    for (int k = 0; k < 3; k++) push(tv(70), 8'hF7);
    b0 = n_burst;
    reg_write(A_STA, 2);
    for (int i = 0; i < 1000 && n_burst < b0 + 3; i++) @(negedge clk);
    reg_write(A_STA, 0);
    check(start_cyc[b0 + 1] - start_cyc[b0] == PER + 1, "R4 interval 1",
          32'(start_cyc[b0 + 1] - start_cyc[b0]), PER + 1);
    check(start_cyc[b0 + 2] - start_cyc[b0 + 1] == PER + 1, "R4 interval 2",
          32'(start_cyc[b0 + 2] - start_cyc[b0 + 1]), PER + 1);
    sb_req = "R6";
    repeat (5 * PER) @(negedge clk);
    check(n_burst == b0 + 3, "R6 stopped", 32'(n_burst - b0), 3);

    // manual path
    sb_req = "R10";
    x0 = n_xfer;
    reg_write(A_MTX, 32'hABCD_0001);
    repeat (20) @(negedge clk);
    check(n_xfer == x0, "R10 ignored in auto", 32'(n_xfer - x0), 0);
    reg_read(A_MRX, r);
    check(r == 0, "R10 result untouched", r, 0);
    reg_write(A_MODE, 1);
    push(32'hABCD_0002, 8'hFF);
    reg_write(A_MTX, 32'hABCD_0002);
    repeat (20) @(negedge clk);
    check(n_xfer == x0 + 1, "R10 one transfer", 32'(n_xfer - x0), 1);
    reg_read(A_MRX, r);
    check(r == ~32'hABCD_0002, "R10 result", r, ~32'hABCD_0002);

    finish_run();
  end
endmodule